// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Capture

This block is a 16-bit down-counter with two 16-bit companion registers, `RA` and `RB`, and two pins, A and B. A three-bit mode code picks one of three behaviours:

- **Event counting.** The counter steps down on a chosen edge of pin A.
- **PWM.** The counter runs on the instruction-cycle enable (`tc_en`) and reloads from RA and RB in turn. Pin A's output may invert at each reload.
- **Input capture.** The running count is copied into RA on a chosen pin-A edge and into RB on a chosen pin-B edge.

Two sticky interrupt-pending flags, A and B, record the events of the active mode. Software clears them by writing ones to them.

Software reaches the block through a simple write strobe, an address and write data. Read data comes back combinationally from the selected register. A run bit in the control register gates all counting and all pin events. Both pin inputs pass through a two-flop synchroniser and then an edge detector, so any pin effect appears three clock edges after the pin changes.

Top module: `mtmr_top`

## Requirements
- R1: After reset, the count, RA, RB, the control register, both flags and `pin_a_out` are all zero.
- R2: The register map is as follows:
  - Address 0 is the count.
  - Address 1 is RA.
  - Address 2 is RB.
  - Address 3 is the control register: bit 3 is run and bits 2:0 are the mode code {C3,C2,C1}.
  - Address 4 holds the flags: bit 0 is flag A and bit 1 is flag B.
  - Each written register reads back the value written.
- R3: Mode codes 000 and 001 select event counting, on rising and falling edges of pin A respectively. The count drops by one per selected edge, whatever the level of `tc_en`, and the change appears three clock edges after the pin changes.
- R4: In event mode, stepping down from 0 wraps the count to FFFF and sets flag A. A rising edge on pin B sets flag B.
- R5: Mode codes 100 and 101 select PWM:
  - The count drops once per clock in which `tc_en` is 1.
  - Stepping down from 0 loads RA and RB alternately, starting with RA after any control write.
  - A load from RA sets flag A; a load from RB sets flag B.
- R6: Code 101 inverts `pin_a_out` at every PWM reload. Code 100 leaves it unchanged.
- R7: Codes 010, 110, 011 and 111 select capture mode:
  - Bit C1 set selects a falling pin-A edge; clear selects a rising one.
  - Bit C3 set selects a falling pin-B edge; clear selects a rising one.
  - A selected pin-A edge copies the count into RA and sets flag A.
  - A selected pin-B edge copies the count into RB and sets flag B.
- R8: In capture mode the count drops once per clock in which `tc_en` is 1. Stepping down from 0 wraps the count to FFFF and sets flag A.
- R9: While run is 0 the count holds, no capture occurs and no flag is set, whatever the pins and `tc_en` do.
- R10: A flag stays set until a one is written to its bit at address 4. A zero in that bit leaves the flag unchanged.
- R11: A software write to the count, RA or RB takes precedence over a hardware decrement, reload or capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_en | input | 1 | Instruction-cycle enable; advances the counter in PWM and capture modes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| pin_a_in | input | 1 | Pin A input (asynchronous) |
| pin_b_in | input | 1 | Pin B input (asynchronous) |
| pin_a_out | output | 1 | PWM output on pin A |
| irq_a | output | 1 | Interrupt-pending flag A |
| irq_b | output | 1 | Interrupt-pending flag B |

## Verification
The bench covers every mode code and checks the pin-edge polarity that each code selects. Swapping a C1 or C3 decode would capture on the wrong edge, or count on both edges. It runs PWM through both reloads and confirms the RA-then-RB order and which flag each reload sets; a design with the phase inverted would load RB first and raise flag B early. Underflow to FFFF is checked in event and capture modes, and holding `tc_en` low confirms that only PWM and capture depend on it. Separate tests show that a stopped timer ignores pin edges, that writing zero to the flag register leaves the flags set, and that a software count write wins over a decrement in the same cycle.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CNT  = 3'd0,
        ADR_RA   = 3'd1,
        ADR_RB   = 3'd2,
        ADR_CTRL = 3'd3,
        ADR_FLAG = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        MD_EVENT = 2'd0,
        MD_PWM   = 2'd1,
        MD_CAPT  = 2'd2
    } mode_kind_e;

    // The mode code is {C3,C2,C1}.
    // C2 set means capture mode; otherwise C3 chooses PWM over event counting.
    function automatic mode_kind_e decode_kind(input logic [2:0] code);
        if (code[1])      return MD_CAPT;
        else if (code[2]) return MD_PWM;
        else              return MD_EVENT;
    endfunction

endpackage

// File: rtl/mtmr_edge.sv
module mtmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;

    // A detected rising edge must come from a pin sample taken two clocks earlier.
    assert_rise_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> ($past(pin_i, 2) && !$past(pin_i, 3)));

    // A detected falling edge must come from a low pin sample taken two clocks earlier.
    assert_fall_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(pin_i, 2));

endmodule

// File: rtl/mtmr_bus.sv
module mtmr_bus
    import mtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  cnt_i,
    input  logic [WIDTH-1:0]  ra_i,
    input  logic [WIDTH-1:0]  rb_i,
    input  logic              irq_a_i,
    input  logic              irq_b_i,
    output logic              run_o,
    output logic [2:0]        mode_o,
    output logic              ctrl_wr_o,
    output logic              cnt_wr_o,
    output logic              ra_wr_o,
    output logic              rb_wr_o,
    output logic              clr_a_o,
    output logic              clr_b_o
);
    localparam int CTRL_W = 4;

    typedef struct packed {
        logic       run;
        logic [2:0] mode;
    } ctrl_st_t;

    ctrl_st_t ctl_d, ctl_q;
    logic     hit_cnt, hit_ra, hit_rb, hit_ctrl, hit_flag;

    always_comb begin
        hit_cnt  = bus_wr && (bus_addr == ADR_CNT);
        hit_ra   = bus_wr && (bus_addr == ADR_RA);
        hit_rb   = bus_wr && (bus_addr == ADR_RB);
        hit_ctrl = bus_wr && (bus_addr == ADR_CTRL);
        hit_flag = bus_wr && (bus_addr == ADR_FLAG);

        ctl_d = ctl_q;
        if (hit_ctrl) begin
            ctl_d.run  = bus_wdata[3];
            ctl_d.mode = bus_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CNT:  bus_rdata = cnt_i;
            ADR_RA:   bus_rdata = ra_i;
            ADR_RB:   bus_rdata = rb_i;
            ADR_CTRL: bus_rdata[CTRL_W-1:0] = ctl_q;
            ADR_FLAG: bus_rdata[1:0] = {irq_b_i, irq_a_i};
            default:  bus_rdata = '0;
        endcase
    end

    assign run_o     = ctl_q.run;
    assign mode_o    = ctl_q.mode;
    assign ctrl_wr_o = hit_ctrl;
    assign cnt_wr_o  = hit_cnt;
    assign ra_wr_o   = hit_ra;
    assign rb_wr_o   = hit_rb;
    assign clr_a_o   = hit_flag & bus_wdata[0];
    assign clr_b_o   = hit_flag & bus_wdata[1];

    // The control register changes only when it is written.
    assert_ctrl_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADR_CTRL) |=> $stable(ctl_q));

endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tc_en_i,
    input  logic             run_i,
    input  logic [2:0]       mode_i,
    input  logic             ctrl_wr_i,
    input  logic             cnt_wr_i,
    input  logic             ra_wr_i,
    input  logic             rb_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             clr_a_i,
    input  logic             clr_b_i,
    input  logic             a_rise_i,
    input  logic             a_fall_i,
    input  logic             b_rise_i,
    input  logic             b_fall_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] ra_o,
    output logic [WIDTH-1:0] rb_o,
    output logic             irq_a_o,
    output logic             irq_b_o,
    output logic             pin_a_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] ra;
        logic [WIDTH-1:0] rb;
        logic             irq_a;
        logic             irq_b;
        logic             phase;  // 0: next reload from RA, 1: from RB
        logic             pin_a;
    } core_st_t;

    core_st_t   s_d, s_q;
    mode_kind_e kind;
    logic       a_sel, b_sel, dec, at_zero;

    always_comb begin
        kind    = decode_kind(mode_i);
        a_sel   = mode_i[0] ? a_fall_i : a_rise_i;
        b_sel   = mode_i[2] ? b_fall_i : b_rise_i;
        dec     = (kind == MD_EVENT) ? (run_i & a_sel) : (run_i & tc_en_i);
        at_zero = (s_q.cnt == '0);

        s_d = s_q;

        // Clears are applied first so that a hardware set in the same cycle wins.
        if (clr_a_i) s_d.irq_a = 1'b0;
        if (clr_b_i) s_d.irq_b = 1'b0;

        if (dec) begin
            if (kind == MD_PWM && at_zero) begin
                s_d.cnt   = s_q.phase ? s_q.rb : s_q.ra;
                s_d.phase = ~s_q.phase;
                if (s_q.phase) s_d.irq_b = 1'b1;
                else           s_d.irq_a = 1'b1;
                if (mode_i[0]) s_d.pin_a = ~s_q.pin_a;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
                if (at_zero) s_d.irq_a = 1'b1;
            end
        end

        if (run_i && kind == MD_EVENT && b_rise_i) s_d.irq_b = 1'b1;

        if (run_i && kind == MD_CAPT) begin
            if (a_sel) begin
                s_d.ra    = s_q.cnt;
                s_d.irq_a = 1'b1;
            end
            if (b_sel) begin
                s_d.rb    = s_q.cnt;
                s_d.irq_b = 1'b1;
            end
        end

        // Software writes take precedence over any hardware update.
        if (cnt_wr_i) s_d.cnt = wdata_i;
        if (ra_wr_i)  s_d.ra  = wdata_i;
        if (rb_wr_i)  s_d.rb  = wdata_i;
        if (ctrl_wr_i) s_d.phase = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign ra_o    = s_q.ra;
    assign rb_o    = s_q.rb;
    assign irq_a_o = s_q.irq_a;
    assign irq_b_o = s_q.irq_b;
    assign pin_a_o = s_q.pin_a;

    // When stopped, the count holds unless software writes it.
    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr_i) |=> $stable(s_q.cnt));

    // When stopped, no flag rises.
    assert_stopped_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !s_q.irq_a) |=> !s_q.irq_a);

    // Event mode moves the count by at most one step per clock.
    assert_event_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MD_EVENT && !cnt_wr_i && !at_zero) |=>
            (s_q.cnt == $past(s_q.cnt) || s_q.cnt == $past(s_q.cnt) - ONE));

    // A PWM underflow reloads from the register the phase selects.
    assert_pwm_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MD_PWM && run_i && tc_en_i && !cnt_wr_i && at_zero) |=>
            (s_q.cnt == ($past(s_q.phase) ? $past(s_q.rb) : $past(s_q.ra))));

    // Code 100 never changes the pin A output.
    assert_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100) |=> $stable(s_q.pin_a));

    // A selected capture edge on pin A copies the count into RA.
    assert_capture_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MD_CAPT && run_i && a_sel && !ra_wr_i) |=> (s_q.ra == $past(s_q.cnt)));

    // A flag stays set until it is cleared.
    assert_flag_a_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq_a && !clr_a_i) |=> s_q.irq_a);
    assert_flag_b_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq_b && !clr_b_i) |=> s_q.irq_b);

    // A software count write always lands.
    assert_sw_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (s_q.cnt == $past(wdata_i)));

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              pin_a_in,
    input  logic              pin_b_in,
    output logic              pin_a_out,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NPIN = 2;

    logic [NPIN-1:0]  pins, rise, fall;
    logic             run, ctrl_wr, cnt_wr, ra_wr, rb_wr, clr_a, clr_b;
    logic [2:0]       mode;
    logic [WIDTH-1:0] cnt, ra, rb;

    assign pins = {pin_b_in, pin_a_in};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        mtmr_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    mtmr_bus #(.WIDTH(WIDTH)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt),
        .ra_i      (ra),
        .rb_i      (rb),
        .irq_a_i   (irq_a),
        .irq_b_i   (irq_b),
        .run_o     (run),
        .mode_o    (mode),
        .ctrl_wr_o (ctrl_wr),
        .cnt_wr_o  (cnt_wr),
        .ra_wr_o   (ra_wr),
        .rb_wr_o   (rb_wr),
        .clr_a_o   (clr_a),
        .clr_b_o   (clr_b)
    );

    mtmr_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc_en_i   (tc_en),
        .run_i     (run),
        .mode_i    (mode),
        .ctrl_wr_i (ctrl_wr),
        .cnt_wr_i  (cnt_wr),
        .ra_wr_i   (ra_wr),
        .rb_wr_i   (rb_wr),
        .wdata_i   (bus_wdata),
        .clr_a_i   (clr_a),
        .clr_b_i   (clr_b),
        .a_rise_i  (rise[0]),
        .a_fall_i  (fall[0]),
        .b_rise_i  (rise[1]),
        .b_fall_i  (fall[1]),
        .cnt_o     (cnt),
        .ra_o      (ra),
        .rb_o      (rb),
        .irq_a_o   (irq_a),
        .irq_b_o   (irq_b),
        .pin_a_o   (pin_a_out)
    );

endmodule

// File: tb/mtmr_top_tb_top.sv
module mtmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tc_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        pin_a_in = 1'b0;
    logic        pin_b_in = 1'b0;
    logic        pin_a_out, irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CNT = 3'd0, A_RA = 3'd1, A_RB = 3'd2, A_CTRL = 3'd3, A_FLAG = 3'd4;
    localparam logic [15:0] RUN = 16'h0008;

    always #5 clk = ~clk;

    mtmr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc_en     (tc_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_a_in  (pin_a_in),
        .pin_b_in  (pin_b_in),
        .pin_a_out (pin_a_out),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bread(a, v);
        chk(req, $sformatf("reg %0d", a), v, exp);
    endtask

    task automatic stop_and_clear();
        bwrite(A_CTRL, 16'h0);
        bwrite(A_FLAG, 16'h3);
    endtask

    task automatic t_reset();
        rd_chk("R1", A_CNT, 16'h0);
        rd_chk("R1", A_RA, 16'h0);
        rd_chk("R1", A_RB, 16'h0);
        rd_chk("R1", A_CTRL, 16'h0);
        rd_chk("R1", A_FLAG, 16'h0);
        chk("R1", "pin_a_out", {15'h0, pin_a_out}, 16'h0);
    endtask

    task automatic t_regmap();
        bwrite(A_RA, 16'hBEEF);
        bwrite(A_RB, 16'h1357);
        bwrite(A_CNT, 16'h2468);
        bwrite(A_CTRL, 16'h0005);
        rd_chk("R2", A_RA, 16'hBEEF);
        rd_chk("R2", A_RB, 16'h1357);
        rd_chk("R2", A_CNT, 16'h2468);
        rd_chk("R2", A_CTRL, 16'h0005);
        bwrite(A_CTRL, 16'h0);
    endtask

    task automatic t_event();
        tc_en = 1'b0;
        stop_and_clear();
        bwrite(A_CNT, 16'd2);
        bwrite(A_CTRL, RUN | 16'h0);
        pin_a_in = 1'b1; step(4);
        rd_chk("R3 rising counts", A_CNT, 16'd1);
        pin_a_in = 1'b0; step(4);
        rd_chk("R3 falling ignored in 000", A_CNT, 16'd1);
        bwrite(A_CTRL, RUN | 16'h1);
        pin_a_in = 1'b1; step(4);
        rd_chk("R3 rising ignored in 001", A_CNT, 16'd1);
        pin_a_in = 1'b0; step(4);
        rd_chk("R3 falling counts", A_CNT, 16'd0);
        chk("R4", "irq_a before wrap", {15'h0, irq_a}, 16'h0);
        pin_a_in = 1'b1; step(4);
        pin_a_in = 1'b0; step(4);
        rd_chk("R4 wrap", A_CNT, 16'hFFFF);
        chk("R4", "irq_a on wrap", {15'h0, irq_a}, 16'h1);
        pin_b_in = 1'b1; step(4);
        chk("R4", "irq_b on pin B rise", {15'h0, irq_b}, 16'h1);
        pin_b_in = 1'b0; step(4);
    endtask

    task automatic t_pwm();
        tc_en = 1'b0;
        stop_and_clear();
        bwrite(A_RA, 16'd3);
        bwrite(A_RB, 16'd5);
        bwrite(A_CNT, 16'd2);
        bwrite(A_CTRL, RUN | 16'h5);
        step(3);
        rd_chk("R5 tc_en low holds", A_CNT, 16'd2);
        tc_en = 1'b1;
        step(3);
        rd_chk("R5 reload RA first", A_CNT, 16'd3);
        chk("R5", "irq_a after RA reload", {15'h0, irq_a}, 16'h1);
        chk("R5", "irq_b after RA reload", {15'h0, irq_b}, 16'h0);
        chk("R6", "toggle to 1", {15'h0, pin_a_out}, 16'h1);
        step(4);
        rd_chk("R5 reload RB second", A_CNT, 16'd5);
        chk("R5", "irq_b after RB reload", {15'h0, irq_b}, 16'h1);
        chk("R6", "toggle back to 0", {15'h0, pin_a_out}, 16'h0);
        tc_en = 1'b0;
        stop_and_clear();
        bwrite(A_CNT, 16'd1);
        bwrite(A_CTRL, RUN | 16'h4);
        tc_en = 1'b1;
        step(2);
        rd_chk("R5 RA reload after ctrl write", A_CNT, 16'd3);
        chk("R6", "no toggle in 100", {15'h0, pin_a_out}, 16'h0);
        chk("R5", "irq_a code 100", {15'h0, irq_a}, 16'h1);
        bwrite(A_CNT, 16'h1234);
        rd_chk("R11 write beats decrement", A_CNT, 16'h1234);
        step(1);
        rd_chk("R11 counting resumes", A_CNT, 16'h1233);
        tc_en = 1'b0;
    endtask

    task automatic t_capture();
        tc_en = 1'b0;
        stop_and_clear();
        bwrite(A_RA, 16'h0);
        bwrite(A_RB, 16'h0);
        bwrite(A_CNT, 16'h0ABC);
        bwrite(A_CTRL, RUN | 16'h6);
        pin_b_in = 1'b1; step(4);
        rd_chk("R7 110 B rise ignored", A_RB, 16'h0);
        chk("R7", "irq_b no capture", {15'h0, irq_b}, 16'h0);
        pin_b_in = 1'b0; step(4);
        rd_chk("R7 110 B fall captures", A_RB, 16'h0ABC);
        chk("R7", "irq_b on capture", {15'h0, irq_b}, 16'h1);
        pin_a_in = 1'b1; step(4);
        rd_chk("R7 110 A rise captures", A_RA, 16'h0ABC);
        chk("R7", "irq_a on capture", {15'h0, irq_a}, 16'h1);
        pin_a_in = 1'b0; step(4);
        stop_and_clear();
        bwrite(A_CNT, 16'h0555);
        bwrite(A_CTRL, RUN | 16'h3);
        pin_a_in = 1'b1; step(4);
        rd_chk("R7 011 A rise ignored", A_RA, 16'h0ABC);
        pin_a_in = 1'b0; step(4);
        rd_chk("R7 011 A fall captures", A_RA, 16'h0555);
        pin_b_in = 1'b1; step(4);
        rd_chk("R7 011 B rise captures", A_RB, 16'h0555);
        pin_b_in = 1'b0; step(4);
        stop_and_clear();
        bwrite(A_CNT, 16'd1);
        bwrite(A_CTRL, RUN | 16'h2);
        tc_en = 1'b1;
        step(1);
        rd_chk("R8 tc decrement", A_CNT, 16'd0);
        chk("R8", "irq_a before wrap", {15'h0, irq_a}, 16'h0);
        step(1);
        rd_chk("R8 wrap", A_CNT, 16'hFFFF);
        chk("R8", "irq_a on wrap", {15'h0, irq_a}, 16'h1);
        tc_en = 1'b0;
    endtask

    task automatic t_stopped();
        stop_and_clear();
        bwrite(A_CNT, 16'd7);
        bwrite(A_RA, 16'h1111);
        bwrite(A_CTRL, 16'h2);
        tc_en = 1'b1;
        pin_a_in = 1'b1; step(4);
        pin_b_in = 1'b1; step(4);
        rd_chk("R9 count holds", A_CNT, 16'd7);
        rd_chk("R9 no capture", A_RA, 16'h1111);
        rd_chk("R9 no flags", A_FLAG, 16'h0);
        tc_en = 1'b0;
        pin_a_in = 1'b0; pin_b_in = 1'b0; step(4);
    endtask

    task automatic t_flags();
        stop_and_clear();
        bwrite(A_CTRL, RUN | 16'h2);
        pin_a_in = 1'b1; pin_b_in = 1'b1; step(4);
        rd_chk("R10 both set", A_FLAG, 16'h3);
        bwrite(A_FLAG, 16'h0);
        rd_chk("R10 zero write keeps", A_FLAG, 16'h3);
        bwrite(A_FLAG, 16'h2);
        rd_chk("R10 clear B only", A_FLAG, 16'h1);
        rd_chk("R2 ctrl readback", A_CTRL, 16'h000A);
        pin_a_in = 1'b0; pin_b_in = 1'b0; step(4);
        bwrite(A_CTRL, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regmap();
        t_event();
        t_pwm();
        t_capture();
        t_stopped();
        t_flags();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule